// File: doc/BRIEF.md
# Saturating Receive Statistics Counters

This block holds the statistics that a frame receiver collects. A 16-bit counter tracks the length in bytes of the frame now arriving. It restarts at the first byte of each new frame and keeps its final value after the frame closes, so a status writer can pick it up. Three independent 8-bit error-event counters record three classes of receive error. They stop at their maximum value instead of rolling over, and a read of a counter empties it. A shared interrupt request is high while any error counter stands at or above 192, which gives software time to drain the counters before they stop at their limit.

A fourth counter serves monitor mode, in which frames are checked but not stored. It counts every acceptable frame that completes while monitor mode is on. A frame that ends in a FIFO overflow is not counted. This counter also stops at its limit and clears when read. Every counter value is driven straight from a register. A read strobe marks the cycle in which the host samples a value. The clear takes effect at the following clock edge.

Top module: `rxStatCounters`

## Requirements
- R1: While reset (rstN low) is asserted and in the first cycle after it, every counter output is 0 and irq is 0.
- R2: When byteValid is high and no frame is open, byteCount reads 1 in the next cycle. Each further byteValid within the same frame adds 1, and the new value shows in the next cycle.
- R3: A frameEnd closes the frame, and a byte strobed in the same cycle as frameEnd is still counted. After that, byteCount holds its value until the first byte of the next frame.
- R4: byteCount stops at 65535 and does not wrap, however many further bytes arrive.
- R5: Each of the three error counters (errCount lane i, bits 8*i+7:8*i) adds exactly 1 for each cycle in which its errEvent bit i is high. The other lanes are not affected.
- R6: An error counter at 255 stays at 255 on further events.
- R7: A cycle with errRead bit i high and no event on lane i leaves that lane at 0 in the next cycle.
- R8: In a cycle with both errRead bit i and errEvent bit i high, errCount lane i shows the value from before the event. In the next cycle the lane reads 1.
- R9: irq is 1 exactly while at least one error counter is 192 or more, and 0 otherwise.
- R10: While monitorEn is high, each frameAccepted strobe without a fifoOverflow adds 1 to missCount in the next cycle.
- R11: missCount does not change on a frameAccepted that has fifoOverflow in the same cycle, or on one that arrives while monitorEn is low.
- R12: missCount stops at 255. A missRead strobe clears it to 0, or to 1 if a countable frame completes in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | One received byte in this cycle |
| frameEnd | input | 1 | Current frame ends in this cycle |
| errEvent | input | 3 | One strobe per error class |
| errRead | input | 3 | Read strobe per error counter |
| frameAccepted | input | 1 | An acceptable frame completed |
| fifoOverflow | input | 1 | The receive FIFO overflowed on this frame |
| monitorEn | input | 1 | Monitor mode enabled |
| missRead | input | 1 | Read strobe for the missed-frame counter |
| byteCount | output | 16 | Byte count of the current or last frame |
| errCount | output | 24 | Three 8-bit error counters, lane i in bits 8*i+7:8*i |
| missCount | output | 8 | Missed-frame counter |
| irq | output | 1 | Shared error-counter interrupt |

## Verification
Every counter is one register stage behind its strobe. So a byte, error, accept or read strobe applied in a cycle shows on the outputs in the next cycle. irq follows the error registers with no further delay. The bench applies the strobes just after a rising edge and updates its reference model for that cycle. It queues the expected state after the next rising edge, and a monitor compares that state at the falling edge in between. For a read, the cycle of the strobe itself is checked against the value from before the strobe, and the next cycle is checked against the cleared value.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
  // Number of error-event classes; fixed by the receiver's error taxonomy.
  localparam int unsigned RX_ERR_NUM = 3;

  // Strobes from the control section into the counter datapath.
  typedef struct packed {
    logic                  byteClr;
    logic                  byteInc;
    logic [RX_ERR_NUM-1:0] errInc;
    logic [RX_ERR_NUM-1:0] errClr;
    logic                  missInc;
    logic                  missClr;
  } ctrlStrobes_t;
endpackage

// File: rtl/rxstatSatCounter.sv
module rxstatSatCounter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};
  localparam logic [W-1:0] ONE_VAL = W'(1);

  logic [W-1:0] countQ;
  logic [W-1:0] countD;

  always_comb begin
    countD = countQ;
    if (clr) begin
      countD = inc ? ONE_VAL : '0;
    end else if (inc && (countQ != MAX_VAL)) begin
      countD = countQ + ONE_VAL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) countQ <= '0;
    else       countQ <= countD;
  end

  assign count = countQ;

  // R6 / R4: a full counter stays full
  p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == MAX_VAL && inc && !clr) |=> (countQ == MAX_VAL));

  // R7: plain clear empties the counter
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clr && !inc) |=> (countQ == '0));

  // R8: clear with a simultaneous event leaves exactly one
  p_clr_inc_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clr && inc) |=> (countQ == ONE_VAL));

  // R5: single step below the limit
  p_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !clr && countQ != MAX_VAL) |=> (countQ == $past(countQ) + ONE_VAL));

  // R3: no strobe, no change
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!inc && !clr) |=> $stable(countQ));
endmodule

// File: rtl/rxstatCtrl.sv
module rxstatCtrl
  import rxstat_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  byteValid,
  input  logic                  frameEnd,
  input  logic [RX_ERR_NUM-1:0] errEvent,
  input  logic [RX_ERR_NUM-1:0] errRead,
  input  logic                  frameAccepted,
  input  logic                  fifoOverflow,
  input  logic                  monitorEn,
  input  logic                  missRead,
  output ctrlStrobes_t          strobes
);
  logic inFrame;

  // Frame tracking: the first byte opens a frame, frameEnd closes it.
  always_ff @(posedge clk) begin
    if (!rstN)          inFrame <= 1'b0;
    else if (frameEnd)  inFrame <= 1'b0;
    else if (byteValid) inFrame <= 1'b1;
  end

  always_comb begin
    strobes         = '0;
    strobes.byteInc = byteValid;
    strobes.byteClr = byteValid && !inFrame;
    strobes.errInc  = errEvent;
    strobes.errClr  = errRead;
    strobes.missInc = monitorEn && frameAccepted && !fifoOverflow;
    strobes.missClr = missRead;
  end

  // R2: a frame opens only through a byte
  p_open_by_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inFrame) |-> $past(byteValid));

  // R3: a closing strobe always leaves the frame closed
  p_close_r3: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> !inFrame);
endmodule

// File: rtl/rxstatDatapath.sv
module rxstatDatapath
  import rxstat_pkg::*;
#(
  parameter int unsigned BYTE_W    = 16,
  parameter int unsigned ERR_W     = 8,
  parameter int unsigned MISS_W    = 8,
  parameter int unsigned IRQ_LEVEL = 192
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctrlStrobes_t                     strobes,
  output logic [BYTE_W-1:0]                byteCount,
  output logic [RX_ERR_NUM-1:0][ERR_W-1:0] errCount,
  output logic [MISS_W-1:0]                missCount,
  output logic                             irq
);
  localparam logic [ERR_W-1:0] IRQ_THR = ERR_W'(IRQ_LEVEL);

  logic [RX_ERR_NUM-1:0] overLevel;

  rxstatSatCounter #(.W(BYTE_W)) byteCnt_i (
    .clk   (clk),
    .rstN  (rstN),
    .inc   (strobes.byteInc),
    .clr   (strobes.byteClr),
    .count (byteCount)
  );

  for (genvar i = 0; i < RX_ERR_NUM; i++) begin : g_err
    rxstatSatCounter #(.W(ERR_W)) errCnt_i (
      .clk   (clk),
      .rstN  (rstN),
      .inc   (strobes.errInc[i]),
      .clr   (strobes.errClr[i]),
      .count (errCount[i])
    );
    assign overLevel[i] = (errCount[i] >= IRQ_THR);
  end

  rxstatSatCounter #(.W(MISS_W)) missCnt_i (
    .clk   (clk),
    .rstN  (rstN),
    .inc   (strobes.missInc),
    .clr   (strobes.missClr),
    .count (missCount)
  );

  assign irq = |overLevel;

  // R9: the interrupt can only rise after an error event
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(|strobes.errInc));

  // R9: the interrupt can only fall after a counter read
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(|strobes.errClr));
endmodule

// File: rtl/rxStatCounters.sv
module rxStatCounters
  import rxstat_pkg::*;
#(
  parameter int unsigned BYTE_W    = 16,
  parameter int unsigned ERR_W     = 8,
  parameter int unsigned MISS_W    = 8,
  parameter int unsigned IRQ_LEVEL = 192
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        byteValid,
  input  logic                        frameEnd,
  input  logic [RX_ERR_NUM-1:0]       errEvent,
  input  logic [RX_ERR_NUM-1:0]       errRead,
  input  logic                        frameAccepted,
  input  logic                        fifoOverflow,
  input  logic                        monitorEn,
  input  logic                        missRead,
  output logic [BYTE_W-1:0]           byteCount,
  output logic [RX_ERR_NUM*ERR_W-1:0] errCount,
  output logic [MISS_W-1:0]           missCount,
  output logic                        irq
);
  ctrlStrobes_t                     strobes;
  logic [RX_ERR_NUM-1:0][ERR_W-1:0] errLanes;

  rxstatCtrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .byteValid     (byteValid),
    .frameEnd      (frameEnd),
    .errEvent      (errEvent),
    .errRead       (errRead),
    .frameAccepted (frameAccepted),
    .fifoOverflow  (fifoOverflow),
    .monitorEn     (monitorEn),
    .missRead      (missRead),
    .strobes       (strobes)
  );

  rxstatDatapath #(
    .BYTE_W    (BYTE_W),
    .ERR_W     (ERR_W),
    .MISS_W    (MISS_W),
    .IRQ_LEVEL (IRQ_LEVEL)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .byteCount (byteCount),
    .errCount  (errLanes),
    .missCount (missCount),
    .irq       (irq)
  );

  assign errCount = errLanes;

  // R11: an overflowed frame never moves the missed counter
  p_ovf_no_count_r11: assert property (@(posedge clk) disable iff (!rstN)
    (fifoOverflow && !missRead) |=> (missCount == $past(missCount)));

  // R11: outside monitor mode the missed counter is frozen
  p_monitor_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!monitorEn && !missRead) |=> (missCount == $past(missCount)));

  // R1: all clear right after reset
  p_reset_r1: assert property (@(posedge clk)
    !rstN |=> (byteCount == '0 && errCount == '0 && missCount == '0 && !irq));
endmodule

// File: tb/rxStatCounters_tb_top.sv
`timescale 1ns/1ps
module rxStatCounters_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0, frameEnd = 1'b0;
  logic [2:0]  errEvent = '0, errRead = '0;
  logic        frameAccepted = 1'b0, fifoOverflow = 1'b0, monitorEn = 1'b0, missRead = 1'b0;
  logic [15:0] byteCount;
  logic [23:0] errCount;
  logic [7:0]  missCount;
  logic        irq;

  always #2.5 clk = ~clk;

  rxStatCounters dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .frameEnd(frameEnd),
    .errEvent(errEvent), .errRead(errRead), .frameAccepted(frameAccepted),
    .fifoOverflow(fifoOverflow), .monitorEn(monitorEn), .missRead(missRead),
    .byteCount(byteCount), .errCount(errCount), .missCount(missCount), .irq(irq)
  );

  typedef struct {
    int unsigned bc;
    int unsigned e0, e1, e2;
    int unsigned ms;
    bit          ir;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  int          checks = 0, errors = 0;
  int unsigned mByte = 0, mMiss = 0;
  int unsigned mErr[3] = '{0, 0, 0};
  bit          mInFrame = 0;
  bit          done = 0;

  function automatic void pushExp(string tag);
    expItem_t e;
    e.bc = mByte; e.e0 = mErr[0]; e.e1 = mErr[1]; e.e2 = mErr[2]; e.ms = mMiss;
    e.ir = (mErr[0] >= 192) || (mErr[1] >= 192) || (mErr[2] >= 192);
    e.tag = tag;
    expQ.push_back(e);
  endfunction

  // Driver: apply one cycle of strobes, advance the reference model, queue the result.
  task automatic step(bit bv, bit fe, bit [2:0] ev, bit [2:0] rd,
                      bit acc, bit ovf, bit mon, bit rdm, string tag);
    bit countable;
    byteValid = bv; frameEnd = fe; errEvent = ev; errRead = rd;
    frameAccepted = acc; fifoOverflow = ovf; monitorEn = mon; missRead = rdm;
    for (int i = 0; i < 3; i++) begin
      if (rd[i])                    mErr[i] = ev[i] ? 1 : 0;
      else if (ev[i] && mErr[i] < 255) mErr[i]++;
    end
    if (bv) begin
      if (!mInFrame)          mByte = 1;
      else if (mByte < 65535) mByte++;
    end
    if (fe)      mInFrame = 0;
    else if (bv) mInFrame = 1;
    countable = mon && acc && !ovf;
    if (rdm)                        mMiss = countable ? 1 : 0;
    else if (countable && mMiss < 255) mMiss++;
    @(posedge clk); #1;
    pushExp(tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 3'b000, 3'b000, 0, 0, 0, 0, tag);
  endtask

  // Monitor: compare the queued expectation away from the clock edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (byteCount != e.bc[15:0] || errCount[7:0] != e.e0[7:0] ||
          errCount[15:8] != e.e1[7:0] || errCount[23:16] != e.e2[7:0] ||
          missCount != e.ms[7:0] || irq != e.ir) begin
        errors++;
        $display("FAIL %s: got bc=%0d e=%0d/%0d/%0d miss=%0d irq=%0d exp bc=%0d e=%0d/%0d/%0d miss=%0d irq=%0d",
                 e.tag, byteCount, errCount[7:0], errCount[15:8], errCount[23:16], missCount, irq,
                 e.bc, e.e0, e.e1, e.e2, e.ms, e.ir);
      end
    end
  end

  initial begin
    #900000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    pushExp("R1 during reset");
    @(posedge clk); #1;
    rstN = 1'b1;
    pushExp("R1 after reset");

    // R2: five-byte frame, last byte with frameEnd (R3)
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R2 byte count");
    step(1, 1, 0, 0, 0, 0, 0, 0, "R3 last byte with end");
    for (int i = 0; i < 3; i++) idle("R3 hold after end");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R2 restart on new frame");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R2 second byte");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R3 end without byte");
    idle("R3 hold");

    // R5: independent lanes
    step(0, 0, 3'b001, 0, 0, 0, 0, 0, "R5 lane0");
    step(0, 0, 3'b110, 0, 0, 0, 0, 0, "R5 lanes1,2");
    step(0, 0, 3'b111, 0, 0, 0, 0, 0, "R5 all lanes");
    step(0, 0, 3'b100, 0, 0, 0, 0, 0, "R5 lane2");
    // R7: read clears; R8 read with event
    step(0, 0, 3'b000, 3'b001, 0, 0, 0, 0, "R7 read lane0");
    step(0, 0, 3'b100, 3'b100, 0, 0, 0, 0, "R8 read with event lane2");
    idle("R8 after");
    step(0, 0, 3'b000, 3'b010, 0, 0, 0, 0, "R7 read lane1");

    // R9 / R6: drive lane0 up to and past the limit
    for (int i = 0; i < 191; i++) step(0, 0, 3'b001, 0, 0, 0, 0, 0, "R9 below level");
    step(0, 0, 3'b001, 0, 0, 0, 0, 0, "R9 reach 192");
    for (int i = 0; i < 70; i++) step(0, 0, 3'b001, 0, 0, 0, 0, 0, "R6 saturate 255");
    step(0, 0, 3'b000, 3'b001, 0, 0, 0, 0, "R9 read drops irq");
    // R9 on lane1 alone
    for (int i = 0; i < 193; i++) step(0, 0, 3'b010, 0, 0, 0, 0, 0, "R9 lane1 level");
    step(0, 0, 3'b010, 3'b010, 0, 0, 0, 0, "R8 read with event drops irq");
    idle("R9 idle");

    // R10 / R11 / R12: missed counter
    step(0, 0, 0, 0, 1, 0, 1, 0, "R10 count accepted");
    step(0, 0, 0, 0, 1, 0, 1, 0, "R10 count accepted");
    step(0, 0, 0, 0, 1, 1, 1, 0, "R11 overflow ignored");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R11 monitor off ignored");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R11 overflow alone");
    step(0, 0, 0, 0, 0, 0, 1, 1, "R12 read clears");
    step(0, 0, 0, 0, 1, 0, 1, 0, "R10 count again");
    step(0, 0, 0, 0, 1, 0, 1, 1, "R12 read with accept");
    for (int i = 0; i < 260; i++) step(0, 0, 0, 0, 1, 0, 1, 0, "R12 saturate");
    step(0, 0, 0, 0, 0, 0, 1, 1, "R12 read after saturate");

    // R4: frame longer than the counter range
    for (int i = 0; i < 65540; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R4 long frame");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R4 end long frame");
    step(1, 1, 0, 0, 0, 0, 0, 0, "R2 one-byte frame");
    idle("R3 final hold");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule